// File: doc/BRIEF.md
# Power-Fail Save and Power-Up Restore Sequencer

This block decides when a battery-backed style memory copies its volatile contents into nonvolatile cells and when it copies them back. It watches two supply comparator flags: one that says the supply is above the switch threshold, and one that says the supply has sagged below the lower reset threshold. Both pass through two-flop synchronizers. When the supply drops through the switch threshold, the block pulls the shared open-drain busy line low for a fixed pulse. If the memory has been written since the last nonvolatile cycle, the block then runs a save. If the memory is clean, it lets go of the line.

A restore is armed only by a dip below the reset level. Power-on reset also arms one. The restore starts once the supply comes back above the switch threshold. While the supply is low, or while any nonvolatile cycle runs, new memory writes are blocked. During the save and restore phases, memory access is disabled outright.

A pin request saves only when the memory is dirty. A software request always saves. An inhibit input turns off the automatic save and leaves both explicit requests working. Every duration is a parameter counted in clock cycles.

Top module: `pwr_nv_seq`

## Requirements
- R1: After reset all outputs are low except `wr_block`, which is high, and a restore is armed, so the first rise of the supply flag starts a restore.
- R2: On a supply fall with the memory dirty, `busy_drive` goes high on the third clock edge after the input change and stays high for PULSE_CYC cycles. A delay window of DELAY_CYC cycles follows, with `busy_drive` high and `mem_off` low. Then a save of STORE_CYC cycles runs, with `store_go`, `mem_off` and `busy_drive` high, before the block returns to idle.
- R3: On a supply fall with the memory clean, `busy_drive` is high for exactly PULSE_CYC cycles and is then released, and no save occurs.
- R4: If the synchronized busy line still reads high at the end of the busy pulse, the block releases `busy_drive` and abandons the save, even when the memory is dirty.
- R5: A restore is armed only while the reset-level flag is asserted. A brown-out that stays above the reset level produces no restore.
- R6: An armed restore begins on the third clock edge after the supply flag rises and lasts RESTORE_CYC cycles, with `recall_go` and `mem_off` high.
- R7: `wr_block` is high while the synchronized supply flag is low or any nonvolatile phase is active. A write pulse presented while `wr_block` is high does not mark the memory dirty.
- R8: With `autosave_off` high, a supply fall starts no busy pulse and no save.
- R9: A pin request (`pin_store_req` high for one cycle, idle, supply high) enters the delay window on the next edge and saves only if the memory is dirty. It is ignored when the memory is clean or the supply is low.
- R10: A software request (`sw_store_req`) under the same conditions saves regardless of the dirty state.
- R11: An accepted write marks the memory dirty. Completing a save or a restore marks it clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_above_sw | input | 1 | Asynchronous flag: supply above switch threshold |
| sup_below_rst | input | 1 | Asynchronous flag: supply below reset threshold |
| autosave_off | input | 1 | Disables the automatic save on power loss |
| wr_pulse | input | 1 | One-cycle pulse per memory write |
| pin_store_req | input | 1 | Conditional save request from the busy pin |
| sw_store_req | input | 1 | Unconditional save request from the software sequence |
| busy_line_in | input | 1 | Sensed level of the shared busy line (high = released) |
| store_go | output | 1 | Save phase active |
| recall_go | output | 1 | Restore phase active |
| busy_drive | output | 1 | Pull the open-drain busy line low |
| mem_off | output | 1 | Memory access disabled |
| wr_block | output | 1 | New memory writes inhibited |

## Verification
Supply falls are applied with the memory dirty, with it clean, with the busy line held high by an outside driver, and with the automatic save inhibited. These four cases separate a full save, a bare pulse, an abort and no reaction at all. Supply dips are applied both with and without the reset-level flag, to show that only a deep dip arms the restore. Pin and software requests are each issued against both a clean and a dirty memory. Because the dirty state has no port of its own, writes made while blocked, and writes made after a save or restore, are checked by whether a later pin request saves.

// File: rtl/pwr_nv_seq.sv
module pwr_nv_seq #(
  parameter int PULSE_CYC   = 50,
  parameter int DELAY_CYC   = 25,
  parameter int STORE_CYC   = 500000,
  parameter int RESTORE_CYC = 27500,
  localparam int CW = $clog2(PULSE_CYC + DELAY_CYC + STORE_CYC + RESTORE_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_above_sw,
  input  logic sup_below_rst,
  input  logic autosave_off,
  input  logic wr_pulse,
  input  logic pin_store_req,
  input  logic sw_store_req,
  input  logic busy_line_in,
  output logic store_go,
  output logic recall_go,
  output logic busy_drive,
  output logic mem_off,
  output logic wr_block
);

  typedef enum logic [2:0] {S_IDLE, S_ATT, S_DLY, S_STO, S_REC} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [1:0] sw_q, br_q, bz_q;
  logic sw_prev, dirty, armed;

  wire sw_s   = sw_q[1];
  wire br_s   = br_q[1];
  wire busy_s = bz_q[1];
  wire sw_fall = sw_prev & ~sw_s;
  wire idle    = (st == S_IDLE);
  wire last    = (cnt == '0);

  wire auto_go = idle & sw_fall & ~autosave_off;
  wire rec_go  = idle & armed & sw_s & ~br_s;
  wire ext_go  = idle & sw_s & (sw_store_req | (pin_store_req & dirty));

  assign store_go   = (st == S_STO);
  assign recall_go  = (st == S_REC);
  assign busy_drive = (st == S_ATT) | (st == S_DLY) | (st == S_STO);
  assign mem_off    = store_go | recall_go;
  assign wr_block   = ~sw_s | ~idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q    <= 2'b00;
      br_q    <= 2'b00;
      bz_q    <= 2'b11;
      sw_prev <= 1'b0;
    end else begin
      sw_q    <= {sw_q[0], sup_above_sw};
      br_q    <= {br_q[0], sup_below_rst};
      bz_q    <= {bz_q[0], busy_line_in};
      sw_prev <= sw_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (auto_go) begin
            st  <= S_ATT;
            cnt <= CW'(PULSE_CYC - 1);
          end else if (rec_go) begin
            st  <= S_REC;
            cnt <= CW'(RESTORE_CYC - 1);
          end else if (ext_go) begin
            st  <= S_DLY;
            cnt <= CW'(DELAY_CYC - 1);
          end
        end
        S_ATT: begin
          if (!last) cnt <= cnt - 1'b1;
          else if (!busy_s && dirty) begin
            st  <= S_DLY;
            cnt <= CW'(DELAY_CYC - 1);
          end else st <= S_IDLE;
        end
        S_DLY: begin
          if (!last) cnt <= cnt - 1'b1;
          else begin
            st  <= S_STO;
            cnt <= CW'(STORE_CYC - 1);
          end
        end
        S_STO, S_REC: begin
          if (!last) cnt <= cnt - 1'b1;
          else st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty <= 1'b0;
      armed <= 1'b1;
    end else begin
      if (mem_off && last) dirty <= 1'b0;
      else if (wr_pulse && !wr_block) dirty <= 1'b1;
      if (br_s) armed <= 1'b1;
      else if (recall_go && last) armed <= 1'b0;
    end
  end

  assert_save_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(store_go) |-> $past(busy_drive));

  assert_abort_on_high_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ATT && last && busy_s) |=> !busy_drive);

  assert_no_recall_unarmed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !armed) |=> !recall_go);

  assert_recall_needs_supply_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recall_go) |-> $past(sw_s));

  assert_blocked_write_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && wr_block && !dirty) |=> !dirty);

  assert_inhibit_no_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (autosave_off && sw_fall && idle) |=> (st != S_ATT));

  assert_clean_after_save_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(store_go) |-> !dirty);

endmodule

// File: tb/test_pwr_nv_seq.sv
module test_pwr_nv_seq;
  localparam int CLK_NS = 10;
  localparam int PULSE = 8, DLY = 4, STO = 20, RST_C = 12;

  logic clk = 0, rst_n = 0;
  logic above = 0, below = 0, inh = 0, wr = 0, pin = 0, swr = 0, hold_high = 0;
  logic store_go, recall_go, busy_drive, mem_off, wr_block;
  wire busy_line = hold_high | ~busy_drive;
  int errs = 0, checks = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  pwr_nv_seq #(.PULSE_CYC(PULSE), .DELAY_CYC(DLY), .STORE_CYC(STO), .RESTORE_CYC(RST_C)) i_pwr_nv_seq (
    .clk(clk), .rst_n(rst_n), .sup_above_sw(above), .sup_below_rst(below),
    .autosave_off(inh), .wr_pulse(wr), .pin_store_req(pin), .sw_store_req(swr),
    .busy_line_in(busy_line), .store_go(store_go), .recall_go(recall_go),
    .busy_drive(busy_drive), .mem_off(mem_off), .wr_block(wr_block));

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic watch(int n, output bit st, output bit rc);
    st = 0; rc = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1);
      st |= store_go; rc |= recall_go;
    end
  endtask

  task automatic do_write();
    wr = 1; cyc(1); wr = 0;
  endtask

  task automatic req_store(bit sw, bit exp, string r);
    if (sw) swr = 1; else pin = 1;
    cyc(1); swr = 0; pin = 0;
    chk({r, " busy on request"}, busy_drive, exp);
    cyc(DLY - 1);
    chk({r, " mem on in delay"}, mem_off, 0);
    cyc(1);
    chk({r, " save start"}, store_go, exp);
    cyc(STO - 1);
    chk({r, " save last"}, store_go, exp);
    cyc(1);
    chk({r, " save end"}, {store_go, busy_drive}, 0);
  endtask

  task automatic t_reset();
    rst_n = 0; above = 0; below = 0; cyc(3); rst_n = 1; cyc(1);
    chk("R1 reset outputs", {store_go, recall_go, busy_drive, mem_off, wr_block}, 5'b00001);
  endtask

  task automatic t_powerup_recall();
    above = 1; cyc(2);
    chk("R6 no restore before sync", recall_go, 0);
    cyc(1);
    chk("R1 R6 restore starts", {recall_go, mem_off, wr_block}, 3'b111);
    cyc(RST_C - 1);
    chk("R6 restore last", recall_go, 1);
    cyc(1);
    chk("R6 restore end", {recall_go, mem_off, wr_block}, 3'b000);
  endtask

  task automatic t_dirty_fail();
    do_write();
    above = 0; cyc(2);
    chk("R2 busy not yet", busy_drive, 0);
    cyc(1);
    chk("R2 busy pulse start", {busy_drive, wr_block}, 2'b11);
    cyc(PULSE - 1);
    chk("R2 busy pulse last", {busy_drive, mem_off}, 2'b10);
    cyc(1);
    chk("R2 delay window", {busy_drive, mem_off, store_go}, 3'b100);
    cyc(DLY - 1);
    chk("R2 delay last", {busy_drive, mem_off}, 2'b10);
    cyc(1);
    chk("R2 save start", {store_go, mem_off, busy_drive}, 3'b111);
    cyc(STO - 1);
    chk("R2 save last", store_go, 1);
    cyc(1);
    chk("R2 save end", {store_go, busy_drive, mem_off}, 0);
    above = 1; cyc(4);
    chk("R5 no restore after shallow dip", recall_go, 0);
    req_store(0, 0, "R11 clean after save pin");
  endtask

  task automatic t_clean_fail();
    bit st, rc;
    above = 0; cyc(3);
    chk("R3 busy pulse", busy_drive, 1);
    cyc(PULSE - 1);
    chk("R3 busy pulse last", busy_drive, 1);
    cyc(1);
    chk("R3 released", busy_drive, 0);
    watch(STO + DLY, st, rc);
    chk("R3 no save", st, 0);
    above = 1; cyc(4);
  endtask

  task automatic t_abort();
    bit st, rc;
    do_write();
    hold_high = 1; above = 0; cyc(3 + PULSE);
    chk("R4 abort release", busy_drive, 0);
    watch(STO + DLY, st, rc);
    chk("R4 no save", st, 0);
    hold_high = 0; above = 1; cyc(4);
    req_store(0, 1, "R4 R9 still dirty pin");
  endtask

  task automatic t_brownout();
    bit st, rc;
    above = 0; cyc(3 + PULSE);
    below = 1; cyc(3); below = 0; cyc(3);
    above = 1; cyc(2);
    chk("R5 deep dip not yet", recall_go, 0);
    cyc(1);
    chk("R5 R6 restore after deep dip", {recall_go, mem_off}, 2'b11);
    cyc(RST_C);
    chk("R6 restore done", recall_go, 0);
    watch(10, st, rc);
    chk("R5 restore disarmed", rc, 0);
  endtask

  task automatic t_write_block();
    bit st, rc;
    inh = 1; above = 0; cyc(3);
    chk("R7 write blocked low supply", wr_block, 1);
    chk("R8 inhibit no pulse", busy_drive, 0);
    do_write();
    watch(PULSE + 4, st, rc);
    chk("R8 inhibit no save", {st, busy_drive}, 0);
    above = 1; cyc(4);
    chk("R7 writes open", wr_block, 0);
    inh = 0; above = 0; cyc(3 + PULSE);
    watch(STO + DLY, st, rc);
    chk("R7 blocked write left clean", st, 0);
    above = 1; cyc(4);
  endtask

  task automatic t_requests();
    req_store(0, 0, "R9 pin clean ignored");
    req_store(1, 1, "R10 software clean saves");
    do_write();
    req_store(0, 1, "R9 R11 pin dirty saves");
    req_store(0, 0, "R11 cleared by save");
    above = 0; cyc(3 + PULSE + 2);
    pin = 1; swr = 1; cyc(1); pin = 0; swr = 0;
    chk("R9 R10 low supply ignored", {busy_drive, store_go}, 0);
    above = 1; cyc(4);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_powerup_recall();
    t_dirty_fail();
    t_clean_fail();
    t_abort();
    t_brownout();
    t_write_block();
    t_requests();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule